// File: doc/BRIEF.md
# Masked I/O Cycle Trap Matcher

The block compares every I/O cycle on a simple cycle strobe against four programmable trap entries. A cycle presents a dword address (bits 15:2 of the I/O address), four active-high byte enables and a direction flag. Each entry can leave the low six dword-address bits, any of the byte enables and the direction as "don't care". One entry can therefore cover an aligned range of up to 256 bytes, and it can cover reads, writes or both.

When a strobed cycle matches at least one enabled entry, the block raises a single-clock system-management interrupt request on the next clock. It also records which entries matched, together with the cycle's address, byte enables and direction, in a status word. That word stays frozen until software clears it by writing ones. Software programs the entries and reads or clears the status through a plain select/write/read register port whose read data is combinational.

Top module: `io_trap_match`

## Requirements
- R1: After reset every trap entry and the status word read back as zero, and `smi_req` and `trap_hits` are low.
- R2: Writing selector 0..3 stores the data into that entry. Only bits 0, 15:2, 23:18, 39:32, 48 and 49 are kept. All other bits read back as zero whatever was written.
- R3: An entry whose bit 0 is 0 never matches, whatever its other fields hold.
- R4: With its address mask zero, an entry matches only when the cycle's dword address equals entry bits 15:2.
- R5: A 1 in entry bit 18+k (k = 0..5) makes dword-address bit k (byte-address bit k+2) a don't-care.
- R6: Entry bits 35:32 must equal the cycle byte enables, except at positions where the byte-enable mask bit (36+k for enable k) is 1.
- R7: Entry bit 48 selects the direction that must match (0 = write, 1 = read). When bit 49 is 1, both directions match and bit 48 is ignored.
- R8: `smi_req` is high for exactly the one clock after a clock edge at which `cyc_valid` was high and at least one entry matched. Otherwise it is low.
- R9: On a trap with an empty status, the status word (selector 4) captures the set of all matching entries in bits 3:0 (bit i for entry i), the byte enables in bits 11:8, the direction in bit 12 (1 = read) and the dword address in bits 29:16. `trap_hits` mirrors bits 3:0.
- R10: While any status hit bit is set, later traps still pulse `smi_req` but leave the status unchanged. Writing selector 4 clears the hit bits where `reg_wdata[3:0]` is 1. Once no hit bit remains, the whole status word reads zero.
- R11: Selectors 5..7 read zero and writes to them have no effect on any entry or on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_valid | input | 1 | Strobe: an I/O cycle is presented this clock |
| cyc_dw_addr | input | 14 | Dword address of the cycle (I/O address bits 15:2) |
| cyc_be | input | 4 | Active-high byte enables of the cycle |
| cyc_read | input | 1 | Cycle direction, 1 = read, 0 = write |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector: 0..3 entries, 4 status |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the selected register |
| smi_req | output | 1 | One-clock interrupt request on a trapped cycle |
| trap_hits | output | 4 | Entries recorded in the held status |

## Verification
A flipped or stuck bit in an entry shows up at the ports in two ways. The entry's readback mismatches on the next read. Matching also goes wrong for one whole slice of the address, byte-enable and direction space. The sweep walks all dword addresses below 0x100, every byte-enable pattern and both directions, so any such slice produces a wrong `smi_req` or status word within one stimulus. A status register that fails to hold or to clear is exposed within two clocks. Either a later trap overwrites the captured cycle, or a cleared word still reads nonzero on the next readback.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;

  localparam int CFG_W    = 64;
  localparam int DW_W     = 14;
  localparam int BE_W     = 4;
  localparam int AMASK_W  = 6;

  // entry field positions
  localparam int EN_BIT   = 0;
  localparam int ADDR_LO  = 2;
  localparam int AMASK_LO = 18;
  localparam int BE_LO    = 32;
  localparam int BEM_LO   = 36;
  localparam int DIR_BIT  = 48;
  localparam int DIRM_BIT = 49;

  // status word field positions
  localparam int ST_HIT_LO  = 0;
  localparam int ST_BE_LO   = 8;
  localparam int ST_RD_BIT  = 12;
  localparam int ST_ADDR_LO = 16;

  typedef struct packed {
    logic [DW_W-1:0] dw_addr;
    logic [BE_W-1:0] be;
    logic            rd;
  } cyc_rec_t;

  function automatic logic [CFG_W-1:0] cfg_keep_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    m[EN_BIT] = 1'b1;
    m[ADDR_LO +: DW_W] = '1;
    m[AMASK_LO +: AMASK_W] = '1;
    m[BE_LO +: BE_W] = '1;
    m[BEM_LO +: BE_W] = '1;
    m[DIR_BIT] = 1'b1;
    m[DIRM_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [CFG_W-1:0] CFG_KEEP = cfg_keep_mask();

endpackage

// File: rtl/trap_cfg_regs.sv
module trap_cfg_regs
  import io_trap_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int SEL_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [CFG_W-1:0]             wr_data,
  output logic [NUM_ENTRIES*CFG_W-1:0] cfg_flat
);

  logic [CFG_W-1:0] wr_clean;

  always_comb begin
    wr_clean = wr_data & CFG_KEEP;
  end

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
    logic             ent_en;
    logic [CFG_W-1:0] ent_d;
    logic [CFG_W-1:0] ent_q;

    always_comb begin
      ent_en = wr_en && (wr_sel == SEL_W'(gi));
      ent_d  = ent_en ? wr_clean : ent_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign cfg_flat[gi*CFG_W +: CFG_W] = ent_q;
  end

endmodule

// File: rtl/trap_entry_cmp.sv
module trap_entry_cmp
  import io_trap_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic [DW_W-1:0]  cyc_dw_addr,
  input  logic [BE_W-1:0]  cyc_be,
  input  logic             cyc_read,
  output logic             hit
);

  logic [DW_W-1:0] addr_dc;
  logic [DW_W-1:0] addr_diff;
  logic [BE_W-1:0] be_diff;
  logic            addr_ok;
  logic            be_ok;
  logic            dir_ok;

  always_comb begin
    addr_dc   = '0;
    addr_dc[AMASK_W-1:0] = cfg[AMASK_LO +: AMASK_W];
    addr_diff = (cyc_dw_addr ^ cfg[ADDR_LO +: DW_W]) & ~addr_dc;
    be_diff   = (cyc_be ^ cfg[BE_LO +: BE_W]) & ~cfg[BEM_LO +: BE_W];
    addr_ok   = (addr_diff == '0);
    be_ok     = (be_diff == '0);
    dir_ok    = cfg[DIRM_BIT] || (cfg[DIR_BIT] == cyc_read);
    hit       = cfg[EN_BIT] && addr_ok && be_ok && dir_ok;
  end

endmodule

// File: rtl/trap_status.sv
module trap_status
  import io_trap_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trap,
  input  logic [NUM_ENTRIES-1:0] match_vec,
  input  cyc_rec_t               cyc_rec,
  input  logic                   clr_en,
  input  logic [NUM_ENTRIES-1:0] clr_bits,
  output logic                   smi_req,
  output logic [NUM_ENTRIES-1:0] st_hits,
  output cyc_rec_t               st_rec
);

  logic [NUM_ENTRIES-1:0] hits_kept;
  logic [NUM_ENTRIES-1:0] hits_d;
  cyc_rec_t               rec_d;
  logic                   capture;
  logic                   st_en;

  always_comb begin
    hits_kept = clr_en ? (st_hits & ~clr_bits) : st_hits;
    capture   = trap && (hits_kept == '0);
    st_en     = capture || clr_en;
    hits_d    = capture ? match_vec : hits_kept;
    if (capture) begin
      rec_d = cyc_rec;
    end else if (hits_kept == '0) begin
      rec_d = '0;
    end else begin
      rec_d = st_rec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_req <= 1'b0;
    end else begin
      smi_req <= trap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_hits <= '0;
      st_rec  <= '0;
    end else if (st_en) begin
      st_hits <= hits_d;
      st_rec  <= rec_d;
    end
  end

endmodule

// File: rtl/io_trap_match.sv
module io_trap_match
  import io_trap_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int SEL_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cyc_valid,
  input  logic [DW_W-1:0]        cyc_dw_addr,
  input  logic [BE_W-1:0]        cyc_be,
  input  logic                   cyc_read,
  input  logic                   reg_wr,
  input  logic [SEL_W-1:0]       reg_sel,
  input  logic [CFG_W-1:0]       reg_wdata,
  output logic [CFG_W-1:0]       reg_rdata,
  output logic                   smi_req,
  output logic [NUM_ENTRIES-1:0] trap_hits
);

  localparam logic [SEL_W-1:0] STATUS_SEL = SEL_W'(NUM_ENTRIES);

  logic [1:0]                   rst_sync_q;
  logic                         rst_core_n;
  logic [NUM_ENTRIES*CFG_W-1:0] cfg_flat;
  logic [NUM_ENTRIES-1:0]       match_vec;
  logic                         trap;
  logic                         clr_en;
  cyc_rec_t                     cyc_rec;
  cyc_rec_t                     st_rec;
  logic [NUM_ENTRIES-1:0]       st_hits;
  logic [CFG_W-1:0]             st_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  trap_cfg_regs #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .SEL_W       (SEL_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (reg_wr),
    .wr_sel   (reg_sel),
    .wr_data  (reg_wdata),
    .cfg_flat (cfg_flat)
  );

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_cmp
    trap_entry_cmp u_cmp (
      .cfg         (cfg_flat[gi*CFG_W +: CFG_W]),
      .cyc_dw_addr (cyc_dw_addr),
      .cyc_be      (cyc_be),
      .cyc_read    (cyc_read),
      .hit         (match_vec[gi])
    );
  end

  always_comb begin
    trap            = cyc_valid && (match_vec != '0);
    clr_en          = reg_wr && (reg_sel == STATUS_SEL);
    cyc_rec.dw_addr = cyc_dw_addr;
    cyc_rec.be      = cyc_be;
    cyc_rec.rd      = cyc_read;
  end

  trap_status #(
    .NUM_ENTRIES (NUM_ENTRIES)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .trap      (trap),
    .match_vec (match_vec),
    .cyc_rec   (cyc_rec),
    .clr_en    (clr_en),
    .clr_bits  (reg_wdata[NUM_ENTRIES-1:0]),
    .smi_req   (smi_req),
    .st_hits   (st_hits),
    .st_rec    (st_rec)
  );

  always_comb begin
    st_word = '0;
    st_word[ST_HIT_LO +: NUM_ENTRIES] = st_hits;
    st_word[ST_BE_LO +: BE_W]         = st_rec.be;
    st_word[ST_RD_BIT]                = st_rec.rd;
    st_word[ST_ADDR_LO +: DW_W]       = st_rec.dw_addr;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (reg_sel == SEL_W'(i)) begin
        reg_rdata = cfg_flat[i*CFG_W +: CFG_W];
      end
    end
    if (reg_sel == STATUS_SEL) begin
      reg_rdata = st_word;
    end
  end

  assign trap_hits = st_hits;

endmodule

// File: rtl/io_trap_match_chk.sv
module io_trap_match_chk
  import io_trap_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int SEL_W = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cyc_valid,
  input logic                         smi_req,
  input logic [NUM_ENTRIES-1:0]       trap_hits,
  input logic                         reg_wr,
  input logic [SEL_W-1:0]             reg_sel,
  input logic [CFG_W-1:0]             reg_wdata,
  input logic [CFG_W-1:0]             reg_rdata,
  input logic [NUM_ENTRIES*CFG_W-1:0] cfg_flat
);

  localparam logic [SEL_W-1:0] STATUS_SEL = SEL_W'(NUM_ENTRIES);

  logic [NUM_ENTRIES-1:0] ent_on;
  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_on
    assign ent_on[gi] = cfg_flat[gi*CFG_W + EN_BIT];
  end

  AST_PULSE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> $past(cyc_valid)); // R8

  AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> ($past(ent_on) != '0)); // R3

  AST_PULSE_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> (trap_hits != '0)); // R9

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((trap_hits != '0) && !(reg_wr && (reg_sel == STATUS_SEL))) |=> $stable(trap_hits)); // R10

  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_sel == STATUS_SEL) && (reg_wdata[NUM_ENTRIES-1:0] == '1))
      |=> ((trap_hits == '0) || $past(cyc_valid))); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel < STATUS_SEL) |-> ((reg_rdata & ~CFG_KEEP) == '0)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel > STATUS_SEL) |-> (reg_rdata == '0)); // R11

endmodule

bind io_trap_match io_trap_match_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .SEL_W       (SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .cyc_valid (cyc_valid),
  .smi_req   (smi_req),
  .trap_hits (trap_hits),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cfg_flat  (cfg_flat)
);

// File: tb/test_io_trap_match.sv
`timescale 1ns/1ps
module test_io_trap_match;

  logic        clk;
  logic        rst_n;
  logic        cyc_valid;
  logic [13:0] cyc_dw_addr;
  logic [3:0]  cyc_be;
  logic        cyc_read;
  logic        reg_wr;
  logic [2:0]  reg_sel;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        smi_req;
  logic [3:0]  trap_hits;

  int checks = 0;
  int errors = 0;
  logic [63:0] tcfg [4];

  io_trap_match i_io_trap_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_valid   (cyc_valid),
    .cyc_dw_addr (cyc_dw_addr),
    .cyc_be      (cyc_be),
    .cyc_read    (cyc_read),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .smi_req     (smi_req),
    .trap_hits   (trap_hits)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] mk_cfg(bit en, logic [15:0] byte_addr, logic [5:0] am,
                                         logic [3:0] be, logic [3:0] bem, bit rd, bit dm);
    logic [63:0] c = '0;
    c[0] = en; c[15:2] = byte_addr[15:2]; c[23:18] = am;
    c[35:32] = be; c[39:36] = bem; c[48] = rd; c[49] = dm;
    return c;
  endfunction

  function automatic bit ent_hit(logic [63:0] c, logic [13:0] dw, logic [3:0] be, bit rd);
    logic [13:0] am = {8'h00, c[23:18]};
    return c[0] && ((dw | am) == (c[15:2] | am))
        && ((be | c[39:36]) == (c[35:32] | c[39:36]))
        && (c[49] || (c[48] == rd));
  endfunction

  function automatic logic [3:0] exp_hits(logic [13:0] dw, logic [3:0] be, bit rd);
    logic [3:0] h;
    for (int i = 0; i < 4; i++) h[i] = ent_hit(tcfg[i], dw, be, rd);
    return h;
  endfunction

  function automatic logic [63:0] st_word(logic [3:0] h, logic [13:0] dw, logic [3:0] be, bit rd);
    logic [63:0] w = '0;
    if (h != 0) begin
      w[3:0] = h; w[11:8] = be; w[12] = rd; w[29:16] = dw;
    end
    return w;
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] sel, logic [63:0] data);
    @(negedge clk);
    reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] sel, logic [63:0] exp);
    reg_sel = sel;
    #1;
    check64(tag, reg_rdata, exp);
  endtask

  task automatic set_entry(int idx, logic [63:0] c);
    tcfg[idx] = c;
    wr_reg(3'(idx), c);
  endtask

  // drive one cycle; returns at the negedge after the capturing edge
  task automatic drive_cyc(logic [13:0] dw, logic [3:0] be, bit rd);
    @(negedge clk);
    reg_sel = 3'd4;
    cyc_valid = 1'b1; cyc_dw_addr = dw; cyc_be = be; cyc_read = rd;
    @(negedge clk);
    cyc_valid = 1'b0;
  endtask

  task automatic sweep_one(logic [13:0] dw, logic [3:0] be, bit rd);
    logic [3:0] h;
    h = exp_hits(dw, be, rd);
    drive_cyc(dw, be, rd);
    // R3 R4 R5 R6 R7 R8 R9 in one combined check
    checks++;
    if (smi_req !== (h != 0) || reg_rdata !== st_word(h, dw, be, rd)) begin
      errors++;
      $display("FAIL R3/R4/R5/R6/R7/R8/R9 dw=%h be=%b rd=%0d actual=%0d/%h expected=%0d/%h",
               dw, be, rd, smi_req, reg_rdata, (h != 0), st_word(h, dw, be, rd));
    end
    reg_wr = 1'b1; reg_wdata = '1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (h != 0) check64("R8 pulse width", {63'd0, smi_req}, 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_valid = 1'b0; cyc_dw_addr = '0; cyc_be = '0; cyc_read = 1'b0;
    reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
    for (int i = 0; i < 4; i++) tcfg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 5; s++) rd_chk("R1 reset readback", 3'(s), 64'd0);
    check64("R1 reset smi_req", {63'd0, smi_req}, 64'd0);
    check64("R1 reset trap_hits", {60'd0, trap_hits}, 64'd0);

    // R2 reserved bits discarded
    wr_reg(3'd3, '1);
    rd_chk("R2 reserved bits", 3'd3, 64'h0003_00FF_00FC_FFFD);
    wr_reg(3'd1, 64'hA5A5_5A5A_A5A5_5A5A);
    rd_chk("R2 pattern", 3'd1, 64'hA5A5_5A5A_A5A5_5A5A & 64'h0003_00FF_00FC_FFFD);

    // R11 unmapped selectors
    wr_reg(3'd6, '1);
    rd_chk("R11 unmapped read", 3'd6, 64'd0);
    rd_chk("R11 no side effect", 3'd0, 64'd0);
    rd_chk("R11 status untouched", 3'd4, 64'd0);

    // configuration, pass one: entry 3 disabled
    set_entry(0, mk_cfg(1, 16'h0120, 6'h0F, 4'b0011, 4'b0000, 0, 0));
    set_entry(1, mk_cfg(1, 16'h0200, 6'h3F, 4'b0000, 4'b1111, 0, 1));
    set_entry(2, mk_cfg(1, 16'h01F0, 6'h00, 4'b1111, 4'b0000, 1, 0));
    set_entry(3, mk_cfg(0, 16'h0100, 6'h3F, 4'b0000, 4'b1111, 0, 1));
    for (int i = 0; i < 4; i++) rd_chk("R2 entry readback", 3'(i), tcfg[i]);

    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 16; b++)
        for (int r = 0; r < 2; r++)
          sweep_one(14'(a), 4'(b), r[0]);

    // pass two: entry 3 enabled, entry 1 disabled
    set_entry(1, mk_cfg(0, 16'h0200, 6'h3F, 4'b0000, 4'b1111, 0, 1));
    set_entry(3, mk_cfg(1, 16'h0100, 6'h3F, 4'b0000, 4'b1111, 0, 1));
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 16; b++)
        for (int r = 0; r < 2; r++)
          sweep_one(14'(a), 4'(b), r[0]);

    // R9 multi-hit, R10 hold and partial clear
    drive_cyc(14'h0048, 4'b0011, 0);
    check64("R9 multi-hit capture", reg_rdata, st_word(4'b1001, 14'h0048, 4'b0011, 0));
    check64("R9 trap_hits mirror", {60'd0, trap_hits}, 64'h9);
    drive_cyc(14'h007C, 4'b1111, 1);
    check64("R10 second trap pulses", {63'd0, smi_req}, 64'd1);
    check64("R10 status held", reg_rdata, st_word(4'b1001, 14'h0048, 4'b0011, 0));
    wr_reg(3'd4, 64'h1);
    rd_chk("R10 partial clear", 3'd4, st_word(4'b1000, 14'h0048, 4'b0011, 0));
    wr_reg(3'd4, 64'h8);
    rd_chk("R10 full clear", 3'd4, 64'd0);
    drive_cyc(14'h007C, 4'b1111, 1);
    check64("R10 recapture after clear", reg_rdata, st_word(4'b1100, 14'h007C, 4'b1111, 1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule